// File: doc/BRIEF.md
# Firmware Image Microcode Loader

This block takes a firmware image one byte per transfer and programs a multi-core coprocessor from it. The image starts with a big-endian header. The loader checks the identifier, the layout version and the record count before it issues any register write. If the header names a device model, that model and its revision must match the device inputs; otherwise the whole image is consumed without effect. After the header comes one record per core. From each record the loader writes the nonzero trap entries and then sets the instruction-RAM pointer. It streams the code words through an indirect data register and finally writes the record's control value. A running CRC over the image is compared with the big-endian CRC at the end, and the total byte count is compared with the header's length field.

All register traffic leaves on one write port that carries an address, data and a one-cycle strobe, with at most one write per cycle. The split-RAM control bit is a level output taken from the header. The loader handles one image per reset.

Top module: `fw_loader`

## Requirements
- R1: After reset, in_ready_o is 1, and wr_en_o, done_o, crc_err_o, split_o and err_o are all 0.
- R2: Bytes 4, 5 and 6 of the image must be 0x51, 0x45 and 0x46. The first byte that differs sets err_o to 1 in the cycle after it is accepted. After that in_ready_o stays 0 and no write is ever issued.
- R3: Byte 7 must equal the VERSION parameter (default 1). If it does not, err_o becomes 2, with the same stop and no-write behaviour as R2.
- R4: Byte 8 must equal the CORES parameter (default 2). If it does not, err_o becomes 3, with the same stop and no-write behaviour as R2.
- R5: split_o takes bit 0 of byte 9 once header byte 13 is accepted, unless the load is skipped under R6. Otherwise it keeps its reset value of 0.
- R6: Bytes 10–11 are a big-endian model number, byte 12 a major revision and byte 13 a minor revision. A model of 0 always loads. For a nonzero model, if any of the three fields differs from dev_model_i, dev_major_i or dev_minor_i, then no write is issued and split_o stays 0. The image is still consumed, and done_o still follows a good CRC.
- R7: Each record opens with 16 big-endian trap words. A nonzero word i of record c is written to TRAP_BASE + 64·c + 4·i (default TRAP_BASE 0x100). A zero word causes no write.
- R8: After the traps, a record holds a 4-byte control value, a 2-byte instruction-RAM offset and a 2-byte word count, all big-endian, then the code words. The offset is written once to address 0x000, then each code word is written in order to address 0x004.
- R9: The record's control value is written to CTRL_BASE + 4·c (default CTRL_BASE 0x200) after the record's last code word. This also happens when the word count is 0.
- R10: Records are applied to cores 0 to CORES−1 in stream order. No write of one record is interleaved with the writes of another.
- R11: Bytes 0–3 are the big-endian total image length, including the 4 CRC bytes. If the accepted byte count at the last CRC byte differs from it, err_o becomes 4 and done_o stays 0.
- R12: The last 4 bytes hold a big-endian CRC-32 of every preceding byte. It uses the reflected polynomial 0xEDB88320, an initial value of 0 and no final inversion. On a match done_o rises in the cycle after the last byte; on a mismatch crc_err_o rises instead. Either flag holds until reset, and in_ready_o stays 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Image byte |
| in_valid_i | input | 1 | Image byte valid |
| in_ready_o | output | 1 | Loader accepts a byte this cycle |
| dev_model_i | input | 16 | Device model number |
| dev_major_i | input | 8 | Device major revision |
| dev_minor_i | input | 8 | Device minor revision |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Register write address |
| wr_data_o | output | 32 | Register write data |
| split_o | output | 1 | Split instruction-RAM control |
| done_o | output | 1 | Image applied and CRC matched |
| crc_err_o | output | 1 | CRC mismatch |
| err_o | output | 3 | Header or length error code |

## Verification
Every result is registered at the edge that accepts the byte which decides it. A trap or code write, an error code, or done_o or crc_err_o is therefore visible one cycle after that byte. The address-register write and the control-value write each take one extra cycle, and in_ready_o is held low during that cycle. The bench drives each byte before a rising edge and returns at the falling edge right after the byte has been accepted. It checks err_o, done_o and crc_err_o at exactly that point. A monitor samples the write port on falling edges and records every strobe in order, and the log is compared with a list the bench builds while it assembles each image.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [3:0] {
    S_HDR, S_TRAP, S_CVAL, S_OFS, S_CNT, S_EADDR, S_CODE, S_ECTRL, S_CRC, S_DONE, S_ERR
  } state_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0,
    E_ID   = 3'd1,
    E_VER  = 3'd2,
    E_CNT  = 3'd3,
    E_LEN  = 3'd4
  } err_e;

  localparam logic [7:0] ID_B0 = 8'h51;
  localparam logic [7:0] ID_B1 = 8'h45;
  localparam logic [7:0] ID_B2 = 8'h46;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

endpackage

// File: rtl/fw_be_word.sv
// Big-endian word assembler: word_o is the current byte appended to the last three.
module fw_be_word (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o
);
  logic [23:0] sh_q;

  assign word_o = {sh_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= word_o[23:0];
  end
endmodule

// File: rtl/fw_crc32.sv
module fw_crc32 import fw_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q ^ {24'd0, byte_i};
    for (int k = 0; k < 8; k++) begin
      crc_d = (crc_d >> 1) ^ (crc_d[0] ? CRC_POLY : 32'd0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/fw_loader.sv
module fw_loader import fw_pkg::*; #(
  parameter int unsigned CORES  = 2,
  parameter int unsigned TRAPS  = 16,
  parameter int unsigned ADDR_W = 12,
  parameter logic [7:0]  VERSION = 8'd1,
  parameter logic [ADDR_W-1:0] IRAM_ADDR_REG = 'h000,
  parameter logic [ADDR_W-1:0] IRAM_DATA_REG = 'h004,
  parameter logic [ADDR_W-1:0] TRAP_BASE     = 'h100,
  parameter logic [ADDR_W-1:0] CTRL_BASE     = 'h200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [15:0]       dev_model_i,
  input  logic [7:0]        dev_major_i,
  input  logic [7:0]        dev_minor_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              split_o,
  output logic              done_o,
  output logic              crc_err_o,
  output logic [2:0]        err_o
);
  localparam int unsigned TRAP_BYTES = TRAPS * 4;
  localparam int unsigned IDX_W      = $clog2(TRAP_BYTES) + 1;
  localparam int unsigned CORE_W     = (CORES > 1) ? $clog2(CORES) : 1;
  localparam logic [ADDR_W-1:0] TRAP_STRIDE = ADDR_W'(TRAP_BYTES);
  localparam logic [ADDR_W-1:0] TRAP_END    = TRAP_BASE + ADDR_W'(CORES * TRAP_BYTES);
  localparam logic [IDX_W-1:0]  TRAP_LAST   = IDX_W'(TRAP_BYTES - 1);
  localparam logic [CORE_W-1:0] CORE_LAST   = CORE_W'(CORES - 1);

  state_e state_q, state_d;
  err_e   err_q, err_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CORE_W-1:0] core_q, core_d;
  logic [31:0] len_q, len_d, ctrl_q, ctrl_d, tot_q;
  logic [15:0] model_q, model_d, ofs_q, ofs_d, left_q, left_d;
  logic [7:0]  major_q, major_d;
  logic split_q, split_d, skip_q, skip_d, split_out_q, split_out_d;
  logic done_q, done_d, crcerr_q, crcerr_d;
  logic wr_en_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [31:0] wr_data_d;
  logic [31:0] word, crc_val;
  logic acc;

  assign in_ready_o = state_q inside {S_HDR, S_TRAP, S_CVAL, S_OFS, S_CNT, S_CODE, S_CRC};
  assign acc        = in_valid_i && in_ready_o;

  fw_be_word u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (acc),
    .byte_i (in_data_i),
    .word_o (word)
  );

  // CRC covers every byte before the CRC field itself
  fw_crc32 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (acc && state_q != S_CRC),
    .byte_i (in_data_i),
    .crc_o  (crc_val)
  );

  always_comb begin
    state_d = state_q;  err_d = err_q;     idx_d = idx_q;     core_d = core_q;
    len_d = len_q;      ctrl_d = ctrl_q;   model_d = model_q; ofs_d = ofs_q;
    left_d = left_q;    major_d = major_q; split_d = split_q; skip_d = skip_q;
    split_out_d = split_out_q; done_d = done_q; crcerr_d = crcerr_q;
    wr_en_d = 1'b0; wr_addr_d = '0; wr_data_d = '0;
    case (state_q)
      S_HDR: if (acc) begin
        idx_d = idx_q + 1'b1;
        case (idx_q)
          IDX_W'(3):  len_d = word;
          IDX_W'(4):  if (in_data_i != ID_B0) begin err_d = E_ID; state_d = S_ERR; end
          IDX_W'(5):  if (in_data_i != ID_B1) begin err_d = E_ID; state_d = S_ERR; end
          IDX_W'(6):  if (in_data_i != ID_B2) begin err_d = E_ID; state_d = S_ERR; end
          IDX_W'(7):  if (in_data_i != VERSION) begin err_d = E_VER; state_d = S_ERR; end
          IDX_W'(8):  if (in_data_i != 8'(CORES)) begin err_d = E_CNT; state_d = S_ERR; end
          IDX_W'(9):  split_d = in_data_i[0];
          IDX_W'(11): model_d = word[15:0];
          IDX_W'(12): major_d = in_data_i;
          IDX_W'(13): begin
            skip_d = (model_q != 16'd0) &&
                     (model_q != dev_model_i || major_q != dev_major_i || in_data_i != dev_minor_i);
            if (!skip_d) split_out_d = split_q;
            state_d = S_TRAP;
            idx_d   = '0;
          end
          default: ;
        endcase
      end
      S_TRAP: if (acc) begin
        idx_d = idx_q + 1'b1;
        if (idx_q[1:0] == 2'd3 && word != 32'd0 && !skip_q) begin
          wr_en_d   = 1'b1;
          wr_addr_d = TRAP_BASE + ADDR_W'(core_q) * TRAP_STRIDE
                    + ADDR_W'({idx_q[IDX_W-1:2], 2'b00});
          wr_data_d = word;
        end
        if (idx_q == TRAP_LAST) begin state_d = S_CVAL; idx_d = '0; end
      end
      S_CVAL: if (acc) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(3)) begin ctrl_d = word; state_d = S_OFS; idx_d = '0; end
      end
      S_OFS: if (acc) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(1)) begin ofs_d = word[15:0]; state_d = S_CNT; idx_d = '0; end
      end
      S_CNT: if (acc) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(1)) begin left_d = word[15:0]; state_d = S_EADDR; idx_d = '0; end
      end
      S_EADDR: begin
        if (!skip_q) begin
          wr_en_d = 1'b1; wr_addr_d = IRAM_ADDR_REG; wr_data_d = {16'd0, ofs_q};
        end
        state_d = (left_q == 16'd0) ? S_ECTRL : S_CODE;
        idx_d   = '0;
      end
      S_CODE: if (acc) begin
        idx_d = idx_q + 1'b1;
        if (idx_q[1:0] == 2'd3) begin
          if (!skip_q) begin
            wr_en_d = 1'b1; wr_addr_d = IRAM_DATA_REG; wr_data_d = word;
          end
          left_d = left_q - 16'd1;
          if (left_q == 16'd1) state_d = S_ECTRL;
        end
      end
      S_ECTRL: begin
        if (!skip_q) begin
          wr_en_d   = 1'b1;
          wr_addr_d = CTRL_BASE + ADDR_W'({core_q, 2'b00});
          wr_data_d = ctrl_q;
        end
        idx_d = '0;
        if (core_q == CORE_LAST) state_d = S_CRC;
        else begin core_d = core_q + 1'b1; state_d = S_TRAP; end
      end
      S_CRC: if (acc) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(3)) begin
          if (tot_q + 32'd1 != len_q) begin err_d = E_LEN; state_d = S_ERR; end
          else if (word == crc_val)   begin done_d = 1'b1; state_d = S_DONE; end
          else                        begin crcerr_d = 1'b1; state_d = S_ERR; end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR; err_q <= E_NONE; idx_q <= '0; core_q <= '0;
      len_q <= '0; ctrl_q <= '0; model_q <= '0; ofs_q <= '0; left_q <= '0;
      major_q <= '0; split_q <= 1'b0; skip_q <= 1'b0; split_out_q <= 1'b0;
      done_q <= 1'b0; crcerr_q <= 1'b0; tot_q <= '0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      state_q <= state_d; err_q <= err_d; idx_q <= idx_d; core_q <= core_d;
      len_q <= len_d; ctrl_q <= ctrl_d; model_q <= model_d; ofs_q <= ofs_d;
      left_q <= left_d; major_q <= major_d; split_q <= split_d; skip_q <= skip_d;
      split_out_q <= split_out_d; done_q <= done_d; crcerr_q <= crcerr_d;
      if (acc) tot_q <= tot_q + 32'd1;
      wr_en_o <= wr_en_d; wr_addr_o <= wr_addr_d; wr_data_o <= wr_data_d;
    end
  end

  assign split_o   = split_out_q;
  assign done_o    = done_q;
  assign crc_err_o = crcerr_q;
  assign err_o     = err_q;

  // R2 R3 R4
  hdr_err_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q inside {E_ID, E_VER, E_CNT}) |-> !wr_en_o);

  // R7
  trap_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o >= TRAP_BASE && wr_addr_o < TRAP_END) |-> (wr_data_o != 32'd0));

  // R6
  skip_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> !wr_en_o);

  // R12
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && crc_err_o));

  // R12
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R12
  end_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || crc_err_o || err_o != 3'd0) |-> !in_ready_o);
endmodule

// File: tb/fw_loader_tb.sv
module fw_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 2;

  logic clk, rst_n;
  logic [7:0] in_data;
  logic in_valid, in_ready;
  logic wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic split, done, crc_err;
  logic [2:0] err;

  fw_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .dev_model_i(16'h1234), .dev_major_i(8'd2), .dev_minor_i(8'd1),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .split_o(split),
    .done_o(done), .crc_err_o(crc_err), .err_o(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic clr_log = 1'b0;
  logic [11:0] got_addr [0:255];
  logic [31:0] got_data [0:255];
  int got_n = 0;

  always @(negedge clk) begin
    if (clr_log) got_n = 0;
    else if (rst_n && wr_en) begin
      if (got_n < 256) begin got_addr[got_n] = wr_addr; got_data[got_n] = wr_data; end
      got_n++;
    end
  end

  logic [7:0]  img [0:1023];
  int ip;
  logic [11:0] exp_addr [0:255];
  logic [31:0] exp_data [0:255];
  int exp_n;
  bit stalled;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic push8(input logic [7:0] b);  img[ip] = b; ip++; endtask
  task automatic push16(input logic [15:0] v); push8(v[15:8]); push8(v[7:0]); endtask
  task automatic push32(input logic [31:0] v); push16(v[31:16]); push16(v[15:0]); endtask
  task automatic add_exp(input logic [11:0] a, input logic [31:0] d);
    exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
  endtask

  function automatic logic [31:0] crc_ref(input int n);
    logic [31:0] c = 32'd0;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, img[i]};
      for (int k = 0; k < 8; k++) c = (c >> 1) ^ (c[0] ? 32'hEDB88320 : 32'd0);
    end
    return c;
  endfunction

  task automatic build(input int ver, input int cnt, input bit bad_id, input bit spl,
                       input logic [15:0] model, input logic [7:0] maj, input logic [7:0] mnr,
                       input int n0, input int n1, input bit load, input int len_adj, input bit crc_bad);
    logic [31:0] len, crc;
    ip = 0; exp_n = 0;
    push32(32'd0);
    push8(bad_id ? 8'h58 : 8'h51); push8(8'h45); push8(8'h46);
    push8(8'(ver)); push8(8'(cnt)); push8({7'd0, spl});
    push16(model); push8(maj); push8(mnr);
    for (int c = 0; c < NCORE; c++) begin
      int nc = (c == 0) ? n0 : n1;
      logic [31:0] ctrl = {16'hC0DE, 8'(c), 8'h5A};
      logic [15:0] ofs = 16'h0010 + 16'(c * 64);
      for (int i = 0; i < 16; i++) begin
        logic [31:0] t = (i % 3 == 0) ? 32'd0 : {4'hA, 4'(c), 8'(i), 16'h1234 + 16'(i)};
        push32(t);
        if (load && t != 32'd0) add_exp(12'h100 + 12'(c * 64 + 4 * i), t);
      end
      push32(ctrl); push16(ofs); push16(16'(nc));
      if (load) add_exp(12'h000, {16'd0, ofs});
      for (int w = 0; w < nc; w++) begin
        logic [31:0] cw = {8'hC0 + 8'(c), 8'(w), 16'hBEEF ^ 16'(w * 7)};
        push32(cw);
        if (load) add_exp(12'h004, cw);
      end
      if (load) add_exp(12'h200 + 12'(4 * c), ctrl);
    end
    len = 32'(ip + 4 + len_adj);
    img[0] = len[31:24]; img[1] = len[23:16]; img[2] = len[15:8]; img[3] = len[7:0];
    crc = crc_ref(ip) ^ {31'd0, crc_bad};
    push32(crc);
  endtask

  task automatic send_byte(input logic [7:0] b);
    int t = 0;
    in_data = b; in_valid = 1'b1;
    while (!in_ready && t < 8) begin @(negedge clk); t++; end
    if (!in_ready) stalled = 1'b1;
    else @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stream(input int n, input bit gaps);
    stalled = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (stalled) break;
      if (gaps && i % 5 == 2) @(negedge clk);
      send_byte(img[i]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'd0; clr_log = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; clr_log = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmp_writes(input string req);
    int bad = -1;
    chk(req, "write count", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && (got_addr[i] !== exp_addr[i] || got_data[i] !== exp_data[i])) bad = i;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s write %0d: actual %h:%h expected %h:%h", req, bad,
               got_addr[bad], got_data[bad], exp_addr[bad], exp_data[bad]);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "wr_en", 32'(wr_en), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "crc_err", 32'(crc_err), 32'd0);
    chk("R1", "split", 32'(split), 32'd0);
    chk("R1", "err", 32'(err), 32'd0);
  endtask

  task automatic t_good();
    do_reset();
    build(1, 2, 0, 1, 16'h0000, 8'd0, 8'd0, 3, 1, 1, 0, 0);
    stream(ip, 0);
    chk("R12", "done after last byte", 32'(done), 32'd1);
    chk("R12", "crc_err", 32'(crc_err), 32'd0);
    chk("R11", "err on good length", 32'(err), 32'd0);
    chk("R5", "split", 32'(split), 32'd1);
    cmp_writes("R7 R8 R9 R10");
  endtask

  task automatic t_match_gaps();
    do_reset();
    build(1, 2, 0, 0, 16'h1234, 8'd2, 8'd1, 0, 2, 1, 0, 0);
    stream(ip, 1);
    chk("R6", "done on matching model", 32'(done), 32'd1);
    chk("R5", "split clear", 32'(split), 32'd0);
    cmp_writes("R6 R9 zero count");
  endtask

  task automatic t_mismatch();
    do_reset();
    build(1, 2, 0, 1, 16'h1234, 8'd3, 8'd1, 2, 2, 0, 0, 0);
    stream(ip, 0);
    chk("R6", "done when skipped", 32'(done), 32'd1);
    chk("R6", "split held", 32'(split), 32'd0);
    chk("R6", "no writes", 32'(got_n), 32'd0);
  endtask

  task automatic t_hdr_err(input string req, input int ver, input int cnt, input bit bad_id,
                           input int nbytes, input logic [2:0] code);
    do_reset();
    build(ver, cnt, bad_id, 0, 16'h0000, 8'd0, 8'd0, 1, 1, 1, 0, 0);
    stream(nbytes, 0);
    chk(req, "err code", 32'(err), 32'(code));
    chk(req, "ready low", 32'(in_ready), 32'd0);
    repeat (20) @(negedge clk);
    chk(req, "no writes", 32'(got_n), 32'd0);
  endtask

  task automatic t_len();
    do_reset();
    build(1, 2, 0, 0, 16'h0000, 8'd0, 8'd0, 1, 1, 1, 1, 0);
    stream(ip, 0);
    chk("R11", "err code", 32'(err), 32'd4);
    chk("R11", "done", 32'(done), 32'd0);
  endtask

  task automatic t_crc();
    do_reset();
    build(1, 2, 0, 0, 16'h0000, 8'd0, 8'd0, 2, 0, 1, 0, 1);
    stream(ip, 0);
    chk("R12", "crc_err", 32'(crc_err), 32'd1);
    chk("R12", "done", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk("R12", "crc_err sticky", 32'(crc_err), 32'd1);
    chk("R12", "ready low", 32'(in_ready), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'd0;
    t_reset();
    t_good();
    t_match_gaps();
    t_mismatch();
    t_hdr_err("R2", 1, 2, 1, 5, 3'd1);
    t_hdr_err("R3", 2, 2, 0, 8, 3'd2);
    t_hdr_err("R4", 1, 3, 0, 9, 3'd3);
    t_len();
    t_crc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule